// File: doc/BRIEF.md
# Multichannel Down-Counting Event Timer

This block is a set of independent down-counting timer channels behind a small 32-bit register port. Each channel holds a 64-bit interval and a 64-bit live count. Software starts a channel, and the count falls by one on every tick of that channel's clock divider. When a tick finds the count at zero, the channel expires. It then either reloads and keeps running (periodic) or halts (one-shot). Every expiry sets a pending flag for that channel. The channel's interrupt line is high while that flag is set and the channel's interrupt-enable bit is set.

A channel loaded with all-ones and run periodically serves as a free-running timestamp. Its bit-inverted count rises steadily. Reading the low count word captures the high word in a per-channel shadow, so two word reads give a coherent 64-bit value. Stopping a channel is deliberately not instant: after enable is cleared, the channel keeps decrementing for a fixed number of clock cycles before it halts. Software must wait out that window before it reprograms the channel.

Top module: `evtmr_top`

## Requirements
- R1: After a synchronous active-low reset, every mapped register reads zero, no channel runs and every `irq` bit is low.
- R2: The map is byte-addressed. Offset 0x00 holds the interrupt enables, with bit c for channel c. Offset 0x04 holds the pending flags. Channel c occupies 0x20*c plus: 0x10 control, 0x14 interval low word, 0x18 interval high word, 0x1C count low word, 0x20 count high word. Both interval words read back what was written. Writes to the count words are ignored.
- R3: Writing control with bit 0 (enable) and bit 1 (reload) both set copies the interval into the count and starts the channel. After that, each divider tick lowers the count by one.
- R4: Control bits 6:4 hold k, and the divider ticks once every 2^k clock cycles, with its phase restarted by a reload start. With interval N, the first pending flag appears (N+1)*2^k cycles after the start edge.
- R5: Control bit 7 clear selects periodic mode. A tick that finds the count at zero sets the pending flag and reloads the interval, so the flag recurs every N+1 ticks.
- R6: Control bit 7 set selects one-shot mode. A tick that finds the count at zero sets the pending flag, holds the count at zero, halts the channel and clears the enable bit as read back.
- R7: Writing 1 to bit c of offset 0x04 clears channel c's pending flag. Writing 0 to a bit leaves that flag unchanged.
- R8: `irq[c]` is high exactly when channel c's pending flag and interrupt-enable bit are both set. A flag still sets while its enable bit is clear.
- R9: When an expiry and a write-1-to-clear of the same flag fall in the same cycle, the flag ends set.
- R10: Writing control with bit 0 clear to a running channel does not halt it at once. The count keeps falling on that write's edge and on the next SYNC_CYC edges, and then holds. With k=0 and SYNC_CYC=2, that is three more decrements.
- R11: A read of a channel's count low word captures the current count high word in a shadow. Reads of the count high word return the shadow.
- R12: Writes to unmapped offsets change nothing. Reads of unmapped offsets return zero. The reload bit, bits 3:2 and bits 31:8 of control always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; qualifies `bus_rdata` and the shadow capture |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when `bus_rd` is low |
| irq | output | NUM_CH | Per-channel interrupt level |

## Verification
Two events can land on the same clock edge: a channel's expiry and software's write-1-to-clear of that channel's pending flag. The bench provokes this with a behavioural model that predicts, one cycle ahead, the edge on which channel 0 will find its count at zero. The clear write is placed on exactly that edge. The flag is then read and must still be set. A second overlap is a disable write while the channel is still counting. The bench judges it by the count value that is eventually held.

// File: rtl/evtmr_pkg.sv
// Package: shared widths, control-field positions and the register map
// of the event timer. Assumes byte addressing with 32-bit registers.
package evtmr_pkg;
    localparam int WORD_W      = 32;
    localparam int CNT_W       = 64;
    localparam int PRE_W       = 3;
    localparam int CTL_EN      = 0;
    localparam int CTL_RELOAD  = 1;
    localparam int CTL_PRE_LSB = 4;
    localparam int CTL_ONESHOT = 7;
    localparam int OFS_IRQ_EN  = 'h00;
    localparam int OFS_IRQ_ST  = 'h04;
    localparam int CH_STRIDE   = 'h20;
    localparam int REL_CTL     = 'h10;
    localparam int REL_IVL_LO  = 'h14;
    localparam int REL_IVL_HI  = 'h18;
    localparam int REL_CNT_LO  = 'h1C;
    localparam int REL_CNT_HI  = 'h20;

    // Byte offset of a channel-relative register.
    function automatic int chan_ofs(int ch, int rel);
        return ch * CH_STRIDE + rel;
    endfunction
endpackage

// File: rtl/evtmr_prescale.sv
// Module: per-channel clock divider. It emits a one-cycle tick every
// 2^sel cycles while run is high. The phase restarts on restart.
// Assumes the divider wraps at 2^(2^PRE_W - 1), a multiple of every ratio.
module evtmr_prescale #(
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W = (1 << PRE_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    // Low sel bits of the divider must all be one for a tick.
    always_comb begin
        mask = ~({DIV_W{1'b1}} << sel);
        tick = run && ((div_q & mask) == mask);
    end

    // Free-running divide counter, cleared on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            div_q <= '0;
        end else if (run) begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/evtmr_decode.sv
// Module: address decoder. It turns a byte offset into one-hot hits on
// the shared registers and on each channel's five registers.
// Assumes NUM_CH*0x20+0x20 fits in ADDR_W bits.
module evtmr_decode
    import evtmr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_ien,
    output logic              hit_ist,
    output logic [NUM_CH-1:0] hit_ctl,
    output logic [NUM_CH-1:0] hit_ivl_lo,
    output logic [NUM_CH-1:0] hit_ivl_hi,
    output logic [NUM_CH-1:0] hit_cnt_lo,
    output logic [NUM_CH-1:0] hit_cnt_hi
);
    // Compare the offset against every mapped register.
    always_comb begin
        hit_ien = (addr == ADDR_W'(OFS_IRQ_EN));
        hit_ist = (addr == ADDR_W'(OFS_IRQ_ST));
        for (int c = 0; c < NUM_CH; c++) begin
            hit_ctl[c]    = (addr == ADDR_W'(chan_ofs(c, REL_CTL)));
            hit_ivl_lo[c] = (addr == ADDR_W'(chan_ofs(c, REL_IVL_LO)));
            hit_ivl_hi[c] = (addr == ADDR_W'(chan_ofs(c, REL_IVL_HI)));
            hit_cnt_lo[c] = (addr == ADDR_W'(chan_ofs(c, REL_CNT_LO)));
            hit_cnt_hi[c] = (addr == ADDR_W'(chan_ofs(c, REL_CNT_HI)));
        end
    end
endmodule

// File: rtl/evtmr_chan.sv
// Module: one down-counting channel. It holds the control, interval,
// count and delayed-stop state, and pulses expire when a tick finds the
// count at zero. Assumes SYNC_CYC >= 1.
module evtmr_chan
    import evtmr_pkg::*;
#(
    parameter int SYNC_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic              ivl_lo_we,
    input  logic              ivl_hi_we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] ctl_rd,
    output logic [CNT_W-1:0]  ivl_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              expire
);
    localparam int STOP_W = $clog2(SYNC_CYC + 1);

    logic              en_q;
    logic              oneshot_q;
    logic              run_q;
    logic [PRE_W-1:0]  pre_q;
    logic [STOP_W-1:0] stop_q;
    logic              tick;
    logic              start;
    logic              resume;
    logic              halt_req;

    assign start    = ctl_we &  wdata[CTL_EN] &  wdata[CTL_RELOAD];
    assign resume   = ctl_we &  wdata[CTL_EN] & ~wdata[CTL_RELOAD];
    assign halt_req = ctl_we & ~wdata[CTL_EN];
    assign expire   = tick & (cnt_q == '0) & ~start;
    assign ctl_rd   = {{(WORD_W-8){1'b0}}, oneshot_q, pre_q, 3'b000, en_q};

    evtmr_prescale #(.PRE_W(PRE_W)) pre_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .restart (start),
        .sel     (pre_q),
        .tick    (tick)
    );

    // Control fields; a one-shot expiry drops the enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            oneshot_q <= 1'b0;
            pre_q     <= '0;
        end else if (ctl_we) begin
            en_q      <= wdata[CTL_EN];
            oneshot_q <= wdata[CTL_ONESHOT];
            pre_q     <= wdata[CTL_PRE_LSB +: PRE_W];
        end else if (expire && oneshot_q) begin
            en_q      <= 1'b0;
        end
    end

    // Running state with the delayed stop after enable is cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            stop_q <= '0;
        end else if (start) begin
            run_q  <= 1'b1;
            stop_q <= '0;
        end else if (expire && oneshot_q) begin
            run_q  <= 1'b0;
            stop_q <= '0;
        end else if (resume) begin
            run_q  <= 1'b1;
            stop_q <= '0;
        end else if (halt_req && run_q && stop_q == '0) begin
            stop_q <= STOP_W'(SYNC_CYC);
        end else if (stop_q != '0) begin
            stop_q <= stop_q - 1'b1;
            if (stop_q == STOP_W'(1)) begin
                run_q <= 1'b0;
            end
        end
    end

    // Interval words written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ivl_q <= '0;
        end else begin
            if (ivl_lo_we) ivl_q[WORD_W-1:0]     <= wdata;
            if (ivl_hi_we) ivl_q[CNT_W-1:WORD_W] <= wdata;
        end
    end

    // Count: load on start, decrement per tick, reload or hold at expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= ivl_q;
        end else if (tick) begin
            if (cnt_q == '0) begin
                cnt_q <= oneshot_q ? '0 : ivl_q;
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/evtmr_top.sv
// Module: event timer top. It decodes the register port, holds the
// shared interrupt-enable and pending registers and the count-high
// shadows, and instantiates NUM_CH channels. Assumes one bus access per cycle.
module evtmr_top
    import evtmr_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int ADDR_W   = 8,
    parameter int SYNC_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    logic              hit_ien;
    logic              hit_ist;
    logic [NUM_CH-1:0] hit_ctl;
    logic [NUM_CH-1:0] hit_ivl_lo;
    logic [NUM_CH-1:0] hit_ivl_hi;
    logic [NUM_CH-1:0] hit_cnt_lo;
    logic [NUM_CH-1:0] hit_cnt_hi;
    logic [NUM_CH-1:0] irq_en_q;
    logic [NUM_CH-1:0] irq_st_q;
    logic [NUM_CH-1:0] expire_w;
    logic [WORD_W-1:0] ctl_w    [NUM_CH];
    logic [CNT_W-1:0]  ivl_w    [NUM_CH];
    logic [CNT_W-1:0]  cnt_w    [NUM_CH];
    logic [WORD_W-1:0] shadow_q [NUM_CH];
    logic [WORD_W-1:0] rd_val;

    evtmr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dec_i (
        .addr       (bus_addr),
        .hit_ien    (hit_ien),
        .hit_ist    (hit_ist),
        .hit_ctl    (hit_ctl),
        .hit_ivl_lo (hit_ivl_lo),
        .hit_ivl_hi (hit_ivl_hi),
        .hit_cnt_lo (hit_cnt_lo),
        .hit_cnt_hi (hit_cnt_hi)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        evtmr_chan #(.SYNC_CYC(SYNC_CYC)) chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctl_we    (bus_wr & hit_ctl[c]),
            .ivl_lo_we (bus_wr & hit_ivl_lo[c]),
            .ivl_hi_we (bus_wr & hit_ivl_hi[c]),
            .wdata     (bus_wdata),
            .ctl_rd    (ctl_w[c]),
            .ivl_q     (ivl_w[c]),
            .cnt_q     (cnt_w[c]),
            .expire    (expire_w[c])
        );

        // Capture the high count word when the low word is read.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow_q[c] <= '0;
            end else if (bus_rd && hit_cnt_lo[c]) begin
                shadow_q[c] <= cnt_w[c][CNT_W-1:WORD_W];
            end
        end
    end

    // Interrupt-enable register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en_q <= '0;
        end else if (bus_wr && hit_ien) begin
            irq_en_q <= bus_wdata[NUM_CH-1:0];
        end
    end

    // Pending flags: expiry sets and wins over write-1-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_st_q <= '0;
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (expire_w[c]) begin
                    irq_st_q[c] <= 1'b1;
                end else if (bus_wr && hit_ist && bus_wdata[c]) begin
                    irq_st_q[c] <= 1'b0;
                end
            end
        end
    end

    // Read multiplexer; unmapped offsets fall through to zero.
    always_comb begin
        rd_val = '0;
        if (hit_ien) rd_val = WORD_W'(irq_en_q);
        if (hit_ist) rd_val = WORD_W'(irq_st_q);
        for (int c = 0; c < NUM_CH; c++) begin
            if (hit_ctl[c])    rd_val = ctl_w[c];
            if (hit_ivl_lo[c]) rd_val = ivl_w[c][WORD_W-1:0];
            if (hit_ivl_hi[c]) rd_val = ivl_w[c][CNT_W-1:WORD_W];
            if (hit_cnt_lo[c]) rd_val = cnt_w[c][WORD_W-1:0];
            if (hit_cnt_hi[c]) rd_val = shadow_q[c];
        end
    end

    assign bus_rdata = bus_rd ? rd_val : '0;
    assign irq       = irq_st_q & irq_en_q;
endmodule

// File: rtl/evtmr_checker.sv
// Module: assertion checker for evtmr_top, attached by bind below.
// Assumes the reset is synchronous and active low.
module evtmr_checker
    import evtmr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NUM_CH-1:0] w1c_bits,
    input logic [WORD_W-1:0] bus_rdata,
    input logic [NUM_CH-1:0] irq,
    input logic [NUM_CH-1:0] irq_en,
    input logic [NUM_CH-1:0] irq_st,
    input logic [NUM_CH-1:0] expire
);
    logic mapped;
    logic st_hit;

    // Independent list of mapped offsets.
    always_comb begin
        st_hit = (bus_addr == ADDR_W'(OFS_IRQ_ST));
        mapped = st_hit || (bus_addr == ADDR_W'(OFS_IRQ_EN));
        for (int c = 0; c < NUM_CH; c++) begin
            for (int r = REL_CTL; r <= REL_CNT_HI; r += 4) begin
                if (bus_addr == ADDR_W'(chan_ofs(c, r))) mapped = 1'b1;
            end
        end
    end

    a_r12_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !mapped) |-> (bus_rdata == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        a_r5_expiry_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
            expire[c] |=> irq_st[c]);
        a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && st_hit && w1c_bits[c] && !expire[c]) |=> !irq_st[c]);
        a_r9_flag_rises_only_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_st[c]) |-> $past(expire[c]));
        a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
            irq[c] |-> (irq_en[c] && irq_st[c]));
    end
endmodule

bind evtmr_top evtmr_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .w1c_bits  (bus_wdata[NUM_CH-1:0]),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .irq_en    (irq_en_q),
    .irq_st    (irq_st_q),
    .expire    (expire_w)
);

// File: tb/evtmr_top_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural cycle model of the timer, compared against the
// interrupt outputs on every clock and against every register read.
module evtmr_top_tb_top;
    localparam int NCH  = 2;
    localparam int AW   = 8;
    localparam int SYNC = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NCH-1:0] irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    evtmr_top #(.NUM_CH(NCH), .ADDR_W(AW), .SYNC_CYC(SYNC)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #4 clk = ~clk;

    // Reference model state
    longint unsigned m_cnt [NCH];
    longint unsigned m_ivl [NCH];
    bit              m_en  [NCH];
    bit              m_os  [NCH];
    bit              m_run [NCH];
    int              m_pre [NCH];
    int              m_div [NCH];
    int              m_stop[NCH];
    bit [31:0]       m_sh  [NCH];
    bit [NCH-1:0]    m_st;
    bit [NCH-1:0]    m_ie;

    function automatic int a_ctl(int c);   return 32*c + 16; endfunction
    function automatic int a_ivlo(int c);  return 32*c + 20; endfunction
    function automatic int a_ivhi(int c);  return 32*c + 24; endfunction
    function automatic int a_cnlo(int c);  return 32*c + 28; endfunction
    function automatic int a_cnhi(int c);  return 32*c + 32; endfunction

    function automatic bit m_tick(int c);
        int msk;
        msk = (1 << m_pre[c]) - 1;
        return m_run[c] && ((m_div[c] & msk) == msk);
    endfunction

    function automatic bit m_will_expire(int c);
        return m_tick(c) && (m_cnt[c] == 0);
    endfunction

    function automatic bit [31:0] m_read(int a);
        if (a == 0) return 32'(m_ie);
        if (a == 4) return 32'(m_st);
        for (int c = 0; c < NCH; c++) begin
            if (a == a_ctl(c))  return (32'(m_os[c]) << 7) | (32'(m_pre[c]) << 4) | 32'(m_en[c]);
            if (a == a_ivlo(c)) return m_ivl[c][31:0];
            if (a == a_ivhi(c)) return m_ivl[c][63:32];
            if (a == a_cnlo(c)) return m_cnt[c][31:0];
            if (a == a_cnhi(c)) return m_sh[c];
        end
        return 32'h0;
    endfunction

    // Model update on each rising edge from the driven bus values
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_cnt[c] = 0; m_ivl[c] = 0; m_en[c] = 0; m_os[c] = 0; m_run[c] = 0;
                m_pre[c] = 0; m_div[c] = 0; m_stop[c] = 0; m_sh[c] = 0;
            end
            m_st = '0;
            m_ie = '0;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                bit cw, stt, tk, ex;
                cw  = bus_wr && (int'(bus_addr) == a_ctl(c));
                stt = cw && bus_wdata[0] && bus_wdata[1];
                tk  = m_tick(c);
                ex  = tk && (m_cnt[c] == 0) && !stt;
                if (ex) m_st[c] = 1'b1;
                else if (bus_wr && bus_addr == 4 && bus_wdata[c]) m_st[c] = 1'b0;
                if (bus_rd && int'(bus_addr) == a_cnlo(c)) m_sh[c] = m_cnt[c][63:32];
                if (stt) m_cnt[c] = m_ivl[c];
                else if (tk) m_cnt[c] = (m_cnt[c] == 0) ? (m_os[c] ? 64'd0 : m_ivl[c]) : m_cnt[c] - 1;
                if (stt) m_div[c] = 0;
                else if (m_run[c]) m_div[c] = (m_div[c] + 1) % 128;
                if (stt) begin m_run[c] = 1; m_stop[c] = 0; end
                else if (ex && m_os[c]) begin m_run[c] = 0; m_stop[c] = 0; end
                else if (cw && bus_wdata[0]) begin m_run[c] = 1; m_stop[c] = 0; end
                else if (cw && !bus_wdata[0] && m_run[c] && m_stop[c] == 0) m_stop[c] = SYNC;
                else if (m_stop[c] != 0) begin
                    if (m_stop[c] == 1) m_run[c] = 0;
                    m_stop[c] = m_stop[c] - 1;
                end
                if (cw) begin
                    m_en[c] = bus_wdata[0]; m_os[c] = bus_wdata[7]; m_pre[c] = int'(bus_wdata[6:4]);
                end else if (ex && m_os[c]) m_en[c] = 0;
                if (bus_wr && int'(bus_addr) == a_ivlo(c)) m_ivl[c][31:0]  = bus_wdata;
                if (bus_wr && int'(bus_addr) == a_ivhi(c)) m_ivl[c][63:32] = bus_wdata;
            end
            if (bus_wr && bus_addr == 0) m_ie = bus_wdata[NCH-1:0];
        end
    end

    task automatic chk(bit ok, string tag, longint unsigned act, longint unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // R8: interrupt outputs compared with the model every cycle
    always @(negedge clk) begin
        if (rst_n && !done) chk(irq == (m_st & m_ie), "R8 irq per-cycle", irq, m_st & m_ie);
    end

    task automatic bus_idle();
        @(negedge clk);
        bus_wr = 0; bus_rd = 0;
    endtask

    task automatic bus_write(int a, bit [31:0] d);
        @(negedge clk);
        bus_rd = 0; bus_wr = 1; bus_addr = AW'(a); bus_wdata = d;
    endtask

    task automatic bus_read(int a, string tag, output bit [31:0] v);
        @(negedge clk);
        bus_wr = 0; bus_rd = 1; bus_addr = AW'(a);
        #1;
        v = bus_rdata;
        chk(v == m_read(a), tag, v, m_read(a));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) bus_idle();
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        bit [31:0] v, c0, h;
        int k;
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        chk(irq == '0, "R1 irq after reset", irq, 0);
        for (int c = 0; c < NCH; c++) begin
            bus_read(a_ctl(c), "R1 ctl", v);  chk(v == 0, "R1 ctl zero", v, 0);
            bus_read(a_ivlo(c), "R1 ivl", v); chk(v == 0, "R1 ivl zero", v, 0);
            bus_read(a_cnlo(c), "R1 cnt", v); chk(v == 0, "R1 cnt zero", v, 0);
        end
        bus_read(0, "R1 ien", v); chk(v == 0, "R1 ien zero", v, 0);
        bus_read(4, "R1 ist", v); chk(v == 0, "R1 ist zero", v, 0);

        // R2: interval read-back, count writes ignored
        bus_write(a_ivlo(0), 32'hDEADBEEF);
        bus_write(a_ivhi(0), 32'h00001234);
        bus_write(a_cnlo(0), 32'h0000FFFF);
        bus_write(a_cnhi(0), 32'h0000FFFF);
        bus_read(a_ivlo(0), "R2 ivl lo", v); chk(v == 32'hDEADBEEF, "R2 ivl lo", v, 32'hDEADBEEF);
        bus_read(a_ivhi(0), "R2 ivl hi", v); chk(v == 32'h1234, "R2 ivl hi", v, 32'h1234);
        bus_read(a_cnlo(0), "R2 cnt lo", v); chk(v == 0, "R2 cnt write ignored", v, 0);

        // R3/R5: periodic channel 0, interval 5, divide by 1
        bus_write(0, 32'h3);
        bus_write(a_ivlo(0), 5);
        bus_write(a_ivhi(0), 0);
        bus_write(a_ctl(0), 32'h03);
        bus_read(a_cnlo(0), "R3 loaded", v); chk(v == 5, "R3 count loaded", v, 5);
        bus_read(a_cnlo(0), "R3 decrement", v); chk(v == 4, "R3 count decremented", v, 4);
        idle(20);
        bus_read(a_ctl(0), "R12 ctl readback", v); chk(v == 32'h1, "R12 reload reads zero", v, 1);
        bus_read(4, "R5 periodic flag", v); chk(v[0] == 1'b1, "R5 periodic flag set", v[0], 1);
        bus_read(a_cnlo(0), "R5 periodic count", v); chk(v <= 5, "R5 count stays in range", v, 5);

        // R7: write 0 keeps the flag, write 1 clears (model-judged)
        bus_write(4, 32'h0);
        bus_read(4, "R7 write zero keeps flag", v); chk(v[0] == 1'b1, "R7 zero write no effect", v[0], 1);
        bus_write(4, 32'h1);
        bus_read(4, "R7 w1c", v);

        // R9: clear write on the very edge of an expiry
        k = 0;
        while (k < 50) begin
            @(negedge clk);
            bus_rd = 0; bus_wr = 0;
            if (m_will_expire(0)) begin
                bus_wr = 1; bus_addr = AW'(4); bus_wdata = 32'h1;
                break;
            end
            k++;
        end
        bus_read(4, "R9 collision", v); chk(v[0] == 1'b1, "R9 expiry beats clear", v[0], 1);

        // R11: shadow of the high count word on channel 1
        bus_write(a_ivlo(1), 3);
        bus_write(a_ivhi(1), 2);
        bus_write(a_ctl(1), 32'h03);
        bus_read(a_cnlo(1), "R11 lo", v); chk(v == 3, "R11 lo word", v, 3);
        idle(6);
        bus_read(a_cnhi(1), "R11 hi", h); chk(h == 2, "R11 shadow coherent", h, 2);
        bus_write(a_ctl(1), 32'h00);
        idle(4);

        // R6: one-shot channel 1, interval 3, divide by 4
        bus_write(a_ivlo(1), 3);
        bus_write(a_ivhi(1), 0);
        bus_write(a_ctl(1), 32'hA3);
        idle(30);
        bus_read(a_ctl(1), "R6 ctl", v); chk(v == 32'hA0, "R6 enable cleared", v, 32'hA0);
        bus_read(a_cnlo(1), "R6 cnt", v); chk(v == 0, "R6 count held at zero", v, 0);
        bus_read(4, "R6 flag", v); chk(v[1] == 1'b1, "R6 one-shot flag", v[1], 1);
        idle(10);
        bus_read(4, "R6 flag held", v);

        // R4: divide by 8, interval 2 -> flag after (2+1)*8 cycles
        bus_write(4, 32'h2);
        bus_write(a_ivlo(1), 2);
        bus_write(a_ctl(1), 32'h33);
        k = 0;
        while (k < 200) begin
            @(negedge clk);
            bus_wr = 0; bus_rd = 0;
            k++;
            if (irq[1]) break;
        end
        chk(k == 25, "R4 divider period", k, 25);

        // R8: flag sets while masked; irq follows the enable
        bus_write(0, 32'h0);
        bus_write(4, 32'h3);
        idle(10);
        chk(irq == '0, "R8 masked irq low", irq, 0);
        bus_read(4, "R8 flag while masked", v); chk(v[0] == 1'b1, "R8 flag sets masked", v[0], 1);
        bus_write(0, 32'h1);
        bus_idle();
        chk(irq[0] == 1'b1, "R8 irq after unmask", irq[0], 1);

        // R10: delayed stop after disable
        bus_write(a_ivlo(0), 1000);
        bus_write(a_ctl(0), 32'h03);
        idle(5);
        bus_read(a_cnlo(0), "R10 before", c0);
        bus_write(a_ctl(0), 32'h00);
        idle(8);
        bus_read(a_cnlo(0), "R10 held", v); chk(v == c0 - 4, "R10 stop delay", v, c0 - 4);
        idle(5);
        bus_read(a_cnlo(0), "R10 still held", v); chk(v == c0 - 4, "R10 stopped", v, c0 - 4);

        // R12: unmapped offsets
        bus_write(8, 32'hFFFFFFFF);
        bus_write(12, 32'hFFFFFFFF);
        bus_write(36, 32'hFFFFFFFF);
        bus_read(8, "R12 unmapped 08", v);  chk(v == 0, "R12 unmapped read zero", v, 0);
        bus_read(36, "R12 unmapped 24", v); chk(v == 0, "R12 unmapped read zero", v, 0);
        bus_read(0, "R12 ien untouched", v); chk(v == 1, "R12 ien unchanged", v, 1);
        bus_read(a_ctl(1), "R12 ctl untouched", v);
        bus_idle();

        done = 1;
        summary();
        $finish;
    end
endmodule